// File: doc/BRIEF.md
# Packed Pixel Format Unpacker

This block sits between a frame-buffer word fetcher and a display timing pipeline. It takes 32-bit words through a valid/ready handshake and turns each one into a stream of RGB pixels with 8 bits per channel. The output advances one pixel on each cycle where the pixel-clock enable is high. Four packings are decoded: a 24-bit mode with one pixel per word, and three 16-bit modes with two pixels per word. By default red sits in the low bits of each pixel. A single swap input exchanges red and blue in every mode.

The format select and the swap bit are sampled together with each accepted word. The unpacker holds at most one word. It takes the next word in the same cycle that the last pixel of the current word is consumed, so a steady pixel enable gets a gap-free stream as long as the fetcher keeps up. Channels narrower than 8 bits are widened by copying their top bits into the vacated low bits, so full scale maps to 8'hFF and zero maps to 8'h00.

Top module: `pix_unpack`

## Requirements
- R1: While reset is high and in the first cycle after it falls, pix_valid is 0 and in_ready is 1.
- R2: With fmt_sel = 0 (24-bit), each word yields one pixel: red = bits 7:0, green = bits 15:8, blue = bits 23:16. Bits 31:24 have no effect on the output.
- R3: With fmt_sel = 1 (5:6:5), each 16-bit pixel gives red = bits 4:0, green = bits 10:5, blue = bits 15:11.
- R4: With fmt_sel = 2 (1:5:5:5), each 16-bit pixel gives red = bits 4:0, green = bits 9:5, blue = bits 14:10. Bit 15 has no effect.
- R5: With fmt_sel = 3 (4:4:4:4), each 16-bit pixel gives red = bits 3:0, green = bits 7:4, blue = bits 11:8. Bits 15:12 have no effect.
- R6: A channel of N < 8 bits is widened by placing it in the top N output bits and filling the low bits with its own most significant bits, repeated as needed.
- R7: In the 16-bit modes a word yields two pixels. Bits 15:0 are presented first and bits 31:16 second.
- R8: When swap_rb is 1, the red and blue outputs are exchanged for every format.
- R9: in_ready is 1 exactly when no word is held, or when the pixel on the outputs is the last one of its word and pix_en is 1. A word is accepted when in_valid and in_ready are both 1 at a clock edge.
- R10: fmt_sel and swap_rb are captured with each accepted word. Changing them while a word is held does not affect that word's pixels.
- R11: While pix_valid is 1 and pix_en is 0, the pixel on the outputs and pix_valid stay unchanged at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | 32 | Packed frame-buffer word |
| in_valid | input | 1 | in_word holds a word |
| in_ready | output | 1 | Block takes in_word at this edge if in_valid |
| fmt_sel | input | 2 | 0: 24-bit, 1: 5:6:5, 2: 1:5:5:5, 3: 4:4:4:4 |
| swap_rb | input | 1 | Exchange red and blue |
| pix_en | input | 1 | Pixel-clock enable; consumes the current pixel |
| pix_valid | output | 1 | A pixel is presented |
| pix_r | output | 8 | Red channel |
| pix_g | output | 8 | Green channel |
| pix_b | output | 8 | Blue channel |

## Verification
A word accepted at a clock edge appears on pix_r/pix_g/pix_b with pix_valid in the cycle that follows that edge, with no further register in between. The second pixel of a 16-bit word appears in the cycle after the edge where pix_en consumed the first. in_ready responds to pix_en in the same cycle with no register. The bench therefore drives all inputs just after the falling edge and samples outputs 1 ns later, before the rising edge. It compares them against a queue of expected pixels that it updates at the point each edge takes effect.

// File: rtl/pu_pkg.sv
package pu_pkg;

    localparam int CH_W = 8;

    typedef enum logic [1:0] {
        FMT_RGB24   = 2'd0,
        FMT_RGB565  = 2'd1,
        FMT_RGB1555 = 2'd2,
        FMT_RGB4444 = 2'd3
    } pu_fmt_e;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } pu_rgb_t;

    // widen a 6-bit channel by repeating its top bits
    function automatic logic [CH_W-1:0] widen6(input logic [5:0] v);
        return {v, v[5:4]};
    endfunction

    function automatic logic [CH_W-1:0] widen5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    function automatic logic [CH_W-1:0] widen4(input logic [3:0] v);
        return {v, v};
    endfunction

endpackage

// File: rtl/pu_word_hold.sv
module pu_word_hold
    import pu_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_valid,
    output logic              in_ready,
    input  pu_fmt_e           fmt_in,
    input  logic              swap_in,
    input  logic              take_en,
    output logic              full,
    output logic              half_sel,
    output logic [WORD_W-1:0] word_q,
    output pu_fmt_e           fmt_q,
    output logic              swap_q
);

    logic full_q;
    logic half_q;
    logic last_pix;
    logic take;
    logic accept;

    // a 24-bit word carries one pixel; a 16-bit word is done after its upper half
    assign last_pix = (fmt_q == FMT_RGB24) || half_q;
    assign take     = take_en && full_q;
    assign in_ready = !full_q || (take && last_pix);
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            half_q <= 1'b0;
            word_q <= '0;
            fmt_q  <= FMT_RGB24;
            swap_q <= 1'b0;
        end else if (accept) begin
            full_q <= 1'b1;
            half_q <= 1'b0;
            word_q <= in_word;
            fmt_q  <= fmt_in;
            swap_q <= swap_in;
        end else if (take) begin
            if (last_pix) begin
                full_q <= 1'b0;
                half_q <= 1'b0;
            end else begin
                half_q <= 1'b1;
            end
        end
    end

    assign full     = full_q;
    assign half_sel = half_q;

endmodule

// File: rtl/pu_decode.sv
module pu_decode
    import pu_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] word,
    input  logic              half_sel,
    input  pu_fmt_e           fmt,
    output pu_rgb_t           pix
);

    localparam int HALF_W = WORD_W / 2;
    localparam int LANES  = WORD_W / HALF_W;

    logic [HALF_W-1:0] lane [LANES];

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        assign lane[gi] = word[gi*HALF_W +: HALF_W];
    end

    logic [HALF_W-1:0] h;

    always_comb begin
        h = half_sel ? lane[1] : lane[0];
        unique case (fmt)
            FMT_RGB24: begin
                pix.r = word[7:0];
                pix.g = word[15:8];
                pix.b = word[23:16];
            end
            FMT_RGB565: begin
                pix.r = widen5(h[4:0]);
                pix.g = widen6(h[10:5]);
                pix.b = widen5(h[15:11]);
            end
            FMT_RGB1555: begin
                pix.r = widen5(h[4:0]);
                pix.g = widen5(h[9:5]);
                pix.b = widen5(h[14:10]);
            end
            default: begin
                pix.r = widen4(h[3:0]);
                pix.g = widen4(h[7:4]);
                pix.b = widen4(h[11:8]);
            end
        endcase
    end

endmodule

// File: rtl/pu_chan_order.sv
module pu_chan_order
    import pu_pkg::*;
(
    input  pu_rgb_t pix_in,
    input  logic    swap,
    output pu_rgb_t pix_out
);

    always_comb begin
        pix_out = pix_in;
        if (swap) begin
            pix_out.r = pix_in.b;
            pix_out.b = pix_in.r;
        end
    end

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
    import pu_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        fmt_sel,
    input  logic              swap_rb,
    input  logic              pix_en,
    output logic              pix_valid,
    output logic [CH_W-1:0]   pix_r,
    output logic [CH_W-1:0]   pix_g,
    output logic [CH_W-1:0]   pix_b
);

    logic              full;
    logic              half_sel;
    logic [WORD_W-1:0] word_q;
    pu_fmt_e           fmt_q;
    logic              swap_q;
    pu_rgb_t           raw_pix;
    pu_rgb_t           ord_pix;

    pu_word_hold #(.WORD_W(WORD_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .in_word  (in_word),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .fmt_in   (pu_fmt_e'(fmt_sel)),
        .swap_in  (swap_rb),
        .take_en  (pix_en),
        .full     (full),
        .half_sel (half_sel),
        .word_q   (word_q),
        .fmt_q    (fmt_q),
        .swap_q   (swap_q)
    );

    pu_decode #(.WORD_W(WORD_W)) u_dec (
        .word     (word_q),
        .half_sel (half_sel),
        .fmt      (fmt_q),
        .pix      (raw_pix)
    );

    pu_chan_order u_ord (
        .pix_in  (raw_pix),
        .swap    (swap_q),
        .pix_out (ord_pix)
    );

    assign pix_valid = full;
    assign pix_r     = ord_pix.r;
    assign pix_g     = ord_pix.g;
    assign pix_b     = ord_pix.b;

endmodule

// File: rtl/pu_checker.sv
module pu_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic       pix_en,
    input logic       pix_valid,
    input logic [7:0] pix_r,
    input logic [7:0] pix_g,
    input logic [7:0] pix_b
);

    // R9: ready while a pixel is shown means that pixel is being consumed
    a_r9_ready_needs_take: assert property (@(posedge clk) disable iff (rst)
        (in_ready && pix_valid) |-> pix_en);

    // R9: nothing held means the block must take a word
    a_r9_empty_ready: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |-> in_ready);

    // R9: an accepted word shows up at the next cycle
    a_r9_accept_fills: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> pix_valid);

    // R7: consuming without room for a new word means a second half remains
    a_r7_pair_follows: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_en && !in_ready) |=> pix_valid);

    // R11: stalled pixel holds
    a_r11_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !pix_en) |=>
            (pix_valid && $stable(pix_r) && $stable(pix_g) && $stable(pix_b)));

endmodule

bind pix_unpack pu_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .pix_en    (pix_en),
    .pix_valid (pix_valid),
    .pix_r     (pix_r),
    .pix_g     (pix_g),
    .pix_b     (pix_b)
);

// File: tb/sim_pix_unpack.sv
`timescale 1ns/1ps
module sim_pix_unpack;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] in_word;
    logic        in_valid;
    logic        in_ready;
    logic [1:0]  fmt_sel;
    logic        swap_rb;
    logic        pix_en;
    logic        pix_valid;
    logic [7:0]  pix_r, pix_g, pix_b;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pix_unpack u0 (
        .clk(clk), .rst(rst), .in_word(in_word), .in_valid(in_valid),
        .in_ready(in_ready), .fmt_sel(fmt_sel), .swap_rb(swap_rb),
        .pix_en(pix_en), .pix_valid(pix_valid),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
    );

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
        logic [1:0] fmt;
        logic       swp;
        logic       upper;
    } exp_t;

    exp_t q[$];

    function automatic logic [7:0] rep(input logic [7:0] v, input int n);
        logic [7:0] o;
        for (int i = 0; i < 8; i++) o[7-i] = v[n-1-(i % n)];
        return o;
    endfunction

    function automatic exp_t model(input logic [31:0] w, input logic up,
                                   input logic [1:0] f, input logic s);
        exp_t e;
        logic [15:0] h;
        logic [7:0]  t;
        h = up ? w[31:16] : w[15:0];
        case (f)
            2'd0: begin e.r = w[7:0]; e.g = w[15:8]; e.b = w[23:16]; end
            2'd1: begin e.r = rep({3'b0, h[4:0]}, 5); e.g = rep({2'b0, h[10:5]}, 6);
                        e.b = rep({3'b0, h[15:11]}, 5); end
            2'd2: begin e.r = rep({3'b0, h[4:0]}, 5); e.g = rep({3'b0, h[9:5]}, 5);
                        e.b = rep({3'b0, h[14:10]}, 5); end
            default: begin e.r = rep({4'b0, h[3:0]}, 4); e.g = rep({4'b0, h[7:4]}, 4);
                        e.b = rep({4'b0, h[11:8]}, 4); end
        endcase
        if (s) begin t = e.r; e.r = e.b; e.b = t; end
        e.fmt = f; e.swp = s; e.upper = up;
        return e;
    endfunction

    function automatic string tag_of(input exp_t e);
        if (e.swp) return "R8";
        if (e.upper) return "R7";
        case (e.fmt)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle: drive after the falling edge, sample before the rising edge
    task automatic step(input logic v, input logic [31:0] w, input logic [1:0] f,
                        input logic s, input logic e);
        logic exp_ready;
        int   sz;
        @(negedge clk);
        in_valid = v; in_word = w; fmt_sel = f; swap_rb = s; pix_en = e;
        #1;
        sz = q.size();
        exp_ready = (sz == 0) || (e && sz == 1);
        check("R9 ready", {31'b0, in_ready}, {31'b0, exp_ready});
        check("R11 valid", {31'b0, pix_valid}, {31'b0, sz > 0});
        if (sz > 0) begin
            // R6 widening and R10 capture are covered by the model values
            check(tag_of(q[0]), {8'b0, pix_r, pix_g, pix_b}, {8'b0, q[0].r, q[0].g, q[0].b});
        end
        if (e && sz > 0) void'(q.pop_front());
        if (v && exp_ready) begin
            q.push_back(model(w, 1'b0, f, s));
            if (f != 2'd0) q.push_back(model(w, 1'b1, f, s));
        end
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; in_valid = 1'b0; in_word = '0; fmt_sel = '0; swap_rb = 1'b0; pix_en = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 valid in reset", {31'b0, pix_valid}, 32'd0);
        check("R1 ready in reset", {31'b0, in_ready}, 32'd1);
        @(negedge clk); rst = 1'b0;
        #1;
        check("R1 valid after reset", {31'b0, pix_valid}, 32'd0);
        check("R1 ready after reset", {31'b0, in_ready}, 32'd1);

        // R6: 5-bit full-scale red widens to FF, stalled for a look
        step(1'b1, 32'h0000_001F, 2'd1, 1'b0, 1'b0);
        step(1'b0, 32'h0, 2'd0, 1'b0, 1'b0);
        check("R6 widen 5->8", {24'b0, pix_r}, 32'h0000_00FF);
        step(1'b0, 32'h0, 2'd0, 1'b0, 1'b1);
        step(1'b0, 32'h0, 2'd0, 1'b0, 1'b1);
        // R2: top byte ignored
        step(1'b1, 32'hFF11_2233, 2'd0, 1'b0, 1'b1);
        step(1'b1, 32'h0011_2233, 2'd0, 1'b0, 1'b1);
        // R4: bit 15 ignored; R5: top nibble ignored; R8 swap
        step(1'b1, 32'h8000_7FFF, 2'd2, 1'b0, 1'b1);
        step(1'b0, 32'h0, 2'd0, 1'b0, 1'b1);
        step(1'b1, 32'hF000_0ABC, 2'd3, 1'b1, 1'b1);
        // R10: change fmt/swap while the word is held and stalled
        step(1'b1, 32'h1234_5678, 2'd1, 1'b0, 1'b0);
        step(1'b1, 32'h9999_9999, 2'd3, 1'b1, 1'b0);
        step(1'b1, 32'h9999_9999, 2'd0, 1'b1, 1'b1);
        step(1'b0, 32'h0, 2'd2, 1'b1, 1'b1);
        step(1'b0, 32'h0, 2'd0, 1'b0, 1'b1);
        step(1'b0, 32'h0, 2'd0, 1'b0, 1'b1);

        // random traffic; fmt/swap change every cycle (R10), stalls (R11)
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 4) != 0, $urandom, 2'($urandom), 1'($urandom),
                 ($urandom % 3) != 0);
        end
        for (int i = 0; i < 4; i++) step(1'b0, 32'h0, 2'd0, 1'b0, 1'b1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule